// File: doc/BRIEF.md
# Motor Driver Datagram Sequencer

This block assembles the serial word for a daisy chain of stepper motor driver chips. The datagram is not a fixed shift register. A 64-entry configuration RAM holds one 6-bit entry per datagram bit. Each entry carries a signal-select code and a next-motor flag. After a start pulse the sequencer reads the RAM in ascending address order. For each entry it picks the selected bit from the current motor's signal set (coil A/B current DAC values, phase bits, fast-decay bits) and shifts it out on a serial clock / data / chip-select link.

The next-motor flag moves the signal source on to the following motor. The flag that belongs to the motor named by the last-driver setting closes the datagram. With three 12-bit drivers and a last-driver setting of 2, one datagram is 36 bits long.

The host writes the RAM through a simple address/data/write-enable port. It may do so at any time, for example to turn fast-decay use on or off. Storage is not reset, so the host must load every entry a datagram will read before it sends the first start pulse.

Top module: `dgram_seq`

## Requirements
- R1: During and after reset, and whenever idle, csn_o = 1, sclk_o = 1, sdo_o = 0 and busy_o = 0.
- R2: A start_i pulse while idle makes busy_o = 1, csn_o = 0 and sclk_o = 0 on the next clock, with the first bit already on sdo_o. A start_i pulse while busy_o = 1 is ignored.
- R3: Each bit holds sclk_o low for CLK_HALF clocks and then high for CLK_HALF clocks. sdo_o changes only where sclk_o falls, so the receiver samples on the rising edge.
- R4: Each RAM entry is {next_flag (bit 5), code (bits 4..0)}. Entries are sent one per bit, starting at address 0 and going up one address per bit.
- R5: Code 5'h10 sends 0, and so does every code not listed in R6 or R7.
- R6: Codes 5'h02..5'h05 send bits 2..5 of the current motor's coil A DAC value. 5'h06 sends phase A and 5'h07 sends fast decay A.
- R7: Codes 5'h0A..5'h0D send bits 2..5 of the current motor's coil B DAC value. 5'h0E sends phase B and 5'h0F sends fast decay B.
- R8: The datagram starts with motor 0. After an entry with next_flag = 1 has been sent, later bits come from the next motor's signals.
- R9: The datagram ends after a flagged entry sent while the motor index equals last_drv_i. last_drv_i is sampled at start, and a value above NUM_MOTORS-1 acts as NUM_MOTORS-1.
- R10: If no entry ends the datagram, it ends after the entry at address 63 (64 bits).
- R11: After the high phase of the last bit, csn_o returns to 1, sclk_o stays 1 and busy_o falls, all in the same clock.
- R12: RAM writes are accepted at any time. A write made during a datagram to an entry not yet sent takes effect in that datagram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin a datagram |
| last_drv_i | input | MIDX_W | Index of the last driver in the chain |
| cfg_we_i | input | 1 | Configuration RAM write enable |
| cfg_addr_i | input | AW | Configuration RAM write address |
| cfg_wdata_i | input | 6 | Entry: bit 5 next-motor flag, bits 4..0 code |
| dac_a_i | input | NUM_MOTORS*6 | Coil A DAC values, motor m at [m*6 +: 6] |
| dac_b_i | input | NUM_MOTORS*6 | Coil B DAC values, motor m at [m*6 +: 6] |
| phase_a_i | input | NUM_MOTORS | Coil A phase per motor |
| phase_b_i | input | NUM_MOTORS | Coil B phase per motor |
| fdec_a_i | input | NUM_MOTORS | Coil A fast decay per motor |
| fdec_b_i | input | NUM_MOTORS | Coil B fast decay per motor |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data |
| csn_o | output | 1 | Chip select, active low |
| busy_o | output | 1 | High while a datagram is in progress |

## Verification
The standard three-driver layout is sent with per-motor DAC values that differ and with their complements. This separates a wrong motor index from a wrong DAC bit position. The chain is also shortened to one driver and driven with an out-of-range last-driver value, which shows where the flag count ends the frame. A layout full of unlisted codes with every input at 1 exposes any code that leaks data. A layout with no flags checks the 64-bit cap. RAM rewrites between and during frames, plus a repeated start pulse, show that writes reach the frame and that a running frame cannot be restarted.

// File: rtl/dgram_pkg.sv
package dgram_pkg;
  localparam int ENTRY_W = 6;
  localparam int CODE_W  = 5;
  localparam int DAC_W   = 6;

  typedef struct packed {
    logic              nxt;
    logic [CODE_W-1:0] code;
  } entry_t;

  localparam logic [CODE_W-1:0] C_ZERO  = 5'h10;
  localparam logic [CODE_W-1:0] C_DA2   = 5'h02;
  localparam logic [CODE_W-1:0] C_DA3   = 5'h03;
  localparam logic [CODE_W-1:0] C_DA4   = 5'h04;
  localparam logic [CODE_W-1:0] C_DA5   = 5'h05;
  localparam logic [CODE_W-1:0] C_PHA   = 5'h06;
  localparam logic [CODE_W-1:0] C_FDA   = 5'h07;
  localparam logic [CODE_W-1:0] C_DB2   = 5'h0A;
  localparam logic [CODE_W-1:0] C_DB3   = 5'h0B;
  localparam logic [CODE_W-1:0] C_DB4   = 5'h0C;
  localparam logic [CODE_W-1:0] C_DB5   = 5'h0D;
  localparam logic [CODE_W-1:0] C_PHB   = 5'h0E;
  localparam logic [CODE_W-1:0] C_FDB   = 5'h0F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/dgram_cfg_ram.sv
module dgram_cfg_ram
  import dgram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  entry_t        wdata_i,
  input  logic [AW-1:0] raddr_i,
  output entry_t        rdata_o
);
  // no reset: contents are undefined until the host loads them
  entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // combinational read so the engine can look one entry ahead
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dgram_bit_select.sv
module dgram_bit_select
  import dgram_pkg::*;
#(
  parameter int NUM_MOTORS = 3,
  parameter int MIDX_W     = 2
) (
  input  logic [CODE_W-1:0]           code_i,
  input  logic [MIDX_W-1:0]           motor_i,
  input  logic [NUM_MOTORS*DAC_W-1:0] dac_a_i,
  input  logic [NUM_MOTORS*DAC_W-1:0] dac_b_i,
  input  logic [NUM_MOTORS-1:0]       phase_a_i,
  input  logic [NUM_MOTORS-1:0]       phase_b_i,
  input  logic [NUM_MOTORS-1:0]       fdec_a_i,
  input  logic [NUM_MOTORS-1:0]       fdec_b_i,
  output logic                        bit_o
);
  logic [DAC_W-1:0] dac_a_arr [NUM_MOTORS];
  logic [DAC_W-1:0] dac_b_arr [NUM_MOTORS];

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_unpack
    assign dac_a_arr[m] = dac_a_i[m*DAC_W +: DAC_W];
    assign dac_b_arr[m] = dac_b_i[m*DAC_W +: DAC_W];
  end

  logic              in_range;
  logic [MIDX_W-1:0] idx;
  logic [2:0]        dac_bit;

  assign in_range = (32'(motor_i) < NUM_MOTORS);
  assign idx      = in_range ? motor_i : '0;
  assign dac_bit  = code_i[2:0];

  always_comb begin
    bit_o = 1'b0;
    if (in_range) begin
      unique case (code_i)
        C_DA2, C_DA3, C_DA4, C_DA5: bit_o = dac_a_arr[idx][dac_bit];
        C_DB2, C_DB3, C_DB4, C_DB5: bit_o = dac_b_arr[idx][dac_bit];
        C_PHA:   bit_o = phase_a_i[idx];
        C_PHB:   bit_o = phase_b_i[idx];
        C_FDA:   bit_o = fdec_a_i[idx];
        C_FDB:   bit_o = fdec_b_i[idx];
        default: bit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dgram_engine.sv
module dgram_engine
  import dgram_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_MOTORS = 3,
  parameter int CLK_HALF   = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int MIDX_W    = (NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1,
  localparam int DIV_W     = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MIDX_W-1:0] last_drv_i,
  input  logic              ent_nxt_i,
  input  logic              ent_bit_i,
  output logic [AW-1:0]     rd_addr_o,
  output logic [MIDX_W-1:0] rd_motor_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              csn_o,
  output logic              busy_o
);
  localparam logic [AW-1:0]     LAST_ADDR  = AW'(DEPTH - 1);
  localparam logic [MIDX_W-1:0] MAX_MOTOR  = MIDX_W'(NUM_MOTORS - 1);
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(CLK_HALF - 1);

  eng_state_e        state_q;
  logic [DIV_W-1:0]  div_q;
  logic [AW-1:0]     ptr_q;
  logic [MIDX_W-1:0] motor_q, last_q, last_clamp;
  logic              flag_q, sclk_q, sdo_q, csn_q;
  logic              half_done, frame_end;

  assign last_clamp = (last_drv_i > MAX_MOTOR) ? MAX_MOTOR : last_drv_i;
  assign half_done  = (div_q == DIV_LAST);
  assign frame_end  = (flag_q && (motor_q == last_q)) || (ptr_q == LAST_ADDR);

  // lookahead: the entry for the next bit is read while the current one is on the wire
  assign rd_addr_o  = (state_q == ST_IDLE) ? '0 : ptr_q + AW'(1);
  assign rd_motor_o = (state_q == ST_IDLE) ? '0 : motor_q + MIDX_W'(flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      ptr_q   <= '0;
      motor_q <= '0;
      last_q  <= '0;
      flag_q  <= 1'b0;
      sclk_q  <= 1'b1;
      sdo_q   <= 1'b0;
      csn_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LO;
            div_q   <= '0;
            ptr_q   <= '0;
            motor_q <= '0;
            last_q  <= last_clamp;
            flag_q  <= ent_nxt_i;
            sdo_q   <= ent_bit_i;
            sclk_q  <= 1'b0;
            csn_q   <= 1'b0;
          end
        end
        ST_LO: begin
          if (half_done) begin
            state_q <= ST_HI;
            div_q   <= '0;
            sclk_q  <= 1'b1;
          end else begin
            div_q   <= div_q + DIV_W'(1);
          end
        end
        ST_HI: begin
          if (half_done) begin
            div_q <= '0;
            if (frame_end) begin
              state_q <= ST_IDLE;
              ptr_q   <= '0;
              motor_q <= '0;
              flag_q  <= 1'b0;
              sdo_q   <= 1'b0;
              csn_q   <= 1'b1;
            end else begin
              state_q <= ST_LO;
              ptr_q   <= ptr_q + AW'(1);
              motor_q <= motor_q + MIDX_W'(flag_q);
              flag_q  <= ent_nxt_i;
              sdo_q   <= ent_bit_i;
              sclk_q  <= 1'b0;
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
  assign csn_o  = csn_q;
  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/dgram_seq.sv
module dgram_seq
  import dgram_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int NUM_MOTORS = 3,
  parameter int CLK_HALF   = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int MIDX_W    = (NUM_MOTORS > 1) ? $clog2(NUM_MOTORS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [MIDX_W-1:0]           last_drv_i,
  input  logic                        cfg_we_i,
  input  logic [AW-1:0]               cfg_addr_i,
  input  logic [ENTRY_W-1:0]          cfg_wdata_i,
  input  logic [NUM_MOTORS*DAC_W-1:0] dac_a_i,
  input  logic [NUM_MOTORS*DAC_W-1:0] dac_b_i,
  input  logic [NUM_MOTORS-1:0]       phase_a_i,
  input  logic [NUM_MOTORS-1:0]       phase_b_i,
  input  logic [NUM_MOTORS-1:0]       fdec_a_i,
  input  logic [NUM_MOTORS-1:0]       fdec_b_i,
  output logic                        sclk_o,
  output logic                        sdo_o,
  output logic                        csn_o,
  output logic                        busy_o
);
  entry_t            rd_entry;
  logic [AW-1:0]     rd_addr;
  logic [MIDX_W-1:0] rd_motor;
  logic              sel_bit;

  dgram_cfg_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (entry_t'(cfg_wdata_i)),
    .raddr_i (rd_addr),
    .rdata_o (rd_entry)
  );

  dgram_bit_select #(.NUM_MOTORS(NUM_MOTORS), .MIDX_W(MIDX_W)) u_sel (
    .code_i    (rd_entry.code),
    .motor_i   (rd_motor),
    .dac_a_i   (dac_a_i),
    .dac_b_i   (dac_b_i),
    .phase_a_i (phase_a_i),
    .phase_b_i (phase_b_i),
    .fdec_a_i  (fdec_a_i),
    .fdec_b_i  (fdec_b_i),
    .bit_o     (sel_bit)
  );

  dgram_engine #(
    .DEPTH(DEPTH), .NUM_MOTORS(NUM_MOTORS), .CLK_HALF(CLK_HALF)
  ) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_drv_i (last_drv_i),
    .ent_nxt_i  (rd_entry.nxt),
    .ent_bit_i  (sel_bit),
    .rd_addr_o  (rd_addr),
    .rd_motor_o (rd_motor),
    .sclk_o     (sclk_o),
    .sdo_o      (sdo_o),
    .csn_o      (csn_o),
    .busy_o     (busy_o)
  );
endmodule

module dgram_seq_chk #(
  parameter int DEPTH = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sclk_o,
  input logic sdo_o,
  input logic csn_o,
  input logic busy_o
);
  int unsigned rise_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_cnt <= 0;
    else if (csn_o) rise_cnt <= 0;
    else if (sclk_o && !$past(sclk_o)) rise_cnt <= rise_cnt + 1;
  end

  AST_IDLE_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (csn_o && sclk_o && !sdo_o)); // R1

  AST_START_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csn_o) |-> $past(start_i) && !sclk_o); // R2

  AST_SDO_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o) && !csn_o) |-> $stable(sdo_o)); // R3

  AST_FRAME_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_cnt <= DEPTH); // R10

  AST_END_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(csn_o) |-> sclk_o && $past(sclk_o) && !busy_o); // R11
endmodule

bind dgram_seq dgram_seq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .sclk_o  (sclk_o),
  .sdo_o   (sdo_o),
  .csn_o   (csn_o),
  .busy_o  (busy_o)
);

// File: tb/dgram_seq_test.sv
`timescale 1ns/1ps
module dgram_seq_test;
  localparam int NM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] last_drv = 2'd2;
  logic we = 1'b0;
  logic [5:0] waddr = '0;
  logic [5:0] wdata = '0;
  logic [NM*6-1:0] dac_a = '0, dac_b = '0;
  logic [NM-1:0] ph_a = '0, ph_b = '0, fd_a = '0, fd_b = '0;
  logic sclk, sdo, csn, busy;

  always #5 clk = ~clk;

  dgram_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .last_drv_i(last_drv),
    .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_wdata_i(wdata),
    .dac_a_i(dac_a), .dac_b_i(dac_b), .phase_a_i(ph_a), .phase_b_i(ph_b),
    .fdec_a_i(fd_a), .fdec_b_i(fd_b),
    .sclk_o(sclk), .sdo_o(sdo), .csn_o(csn), .busy_o(busy)
  );

  int n_tests = 0, n_fail = 0;
  logic [5:0] shadow [64];
  logic rx_bits [128];
  int rx_n = 0;
  logic exp_bits [128];
  int exp_n = 0;

  // receiver: samples on rising sclk while csn is low
  initial begin
    forever begin
      @(negedge csn);
      rx_n = 0;
      while (1) begin
        @(posedge sclk or posedge csn);
        if (csn) break;
        if (rx_n < 128) rx_bits[rx_n] = sdo;
        rx_n++;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [5:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 6'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    shadow[a] = d;
  endtask

  function automatic logic ref_bit(logic [4:0] c, int m);
    if (m >= NM) return 1'b0;
    case (c)
      5'h02: return dac_a[m*6+2];
      5'h03: return dac_a[m*6+3];
      5'h04: return dac_a[m*6+4];
      5'h05: return dac_a[m*6+5];
      5'h06: return ph_a[m];
      5'h07: return fd_a[m];
      5'h0A: return dac_b[m*6+2];
      5'h0B: return dac_b[m*6+3];
      5'h0C: return dac_b[m*6+4];
      5'h0D: return dac_b[m*6+5];
      5'h0E: return ph_b[m];
      5'h0F: return fd_b[m];
      default: return 1'b0;
    endcase
  endfunction

  task automatic build_expect(int lastd);
    int eff = (lastd > NM-1) ? NM-1 : lastd;
    int m = 0;
    exp_n = 0;
    for (int a = 0; a < 64; a++) begin
      exp_bits[exp_n] = ref_bit(shadow[a][4:0], m);
      exp_n++;
      if (shadow[a][5]) begin
        if (m == eff) break;
        m++;
      end
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(string req, string what);
    int bad = -1;
    check(rx_n == exp_n, req, {what, " length"}, rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++)
      if (bad < 0 && rx_bits[i] !== exp_bits[i]) bad = i;
    check(bad < 0, req, {what, " first bad bit index"}, bad, -1);
    check(csn && sclk && !busy, "R11", {what, " lines after end"}, {csn, sclk, busy}, 3'b110);
  endtask

  task automatic frame(int lastd, string req, string what);
    last_drv = 2'(lastd);
    build_expect(lastd);
    pulse_start();
    check(busy && !csn && !sclk, "R2", {what, " start response"}, {busy, csn, sclk}, 3'b100);
    wait_done();
    compare(req, what);
  endtask

  // three 12-bit drivers; only the last one uses fast decay
  task automatic load_standard();
    for (int m = 0; m < 3; m++) begin
      int b = m * 12;
      wr(b+0,  (m == 2) ? 6'h07 : 6'h10);
      wr(b+1,  6'h05); wr(b+2, 6'h04); wr(b+3, 6'h03); wr(b+4, 6'h02);
      wr(b+5,  6'h06);
      wr(b+6,  (m == 2) ? 6'h0F : 6'h10);
      wr(b+7,  6'h0D); wr(b+8, 6'h0C); wr(b+9, 6'h0B); wr(b+10, 6'h0A);
      wr(b+11, 6'h2E);
    end
    for (int a = 36; a < 64; a++) wr(a, 6'h10);
  endtask

  task automatic t_reset();
    check(csn && sclk && !sdo && !busy, "R1", "idle lines after reset",
          {csn, sclk, sdo, busy}, 4'b1100);
  endtask

  task automatic t_timing();
    logic [4:0] seen;
    last_drv = 2'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen[4] = sclk;
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      seen[i] = sclk;
    end
    check(seen == 5'b00110, "R3", "sclk low/high phase pattern", seen, 5'b00110);
    wait_done();
  endtask

  task automatic t_three_drivers();
    dac_a = {6'b101100, 6'b010100, 6'b111000};
    dac_b = {6'b001100, 6'b110000, 6'b100100};
    ph_a = 3'b101; ph_b = 3'b011; fd_a = 3'b110; fd_b = 3'b101;
    frame(2, "R6", "three drivers pattern 1 (R4 R7 R8 R9)");
    dac_a = ~dac_a; dac_b = ~dac_b; ph_a = ~ph_a; ph_b = ~ph_b; fd_a = ~fd_a; fd_b = ~fd_b;
    frame(2, "R8", "three drivers pattern 2 (R4 R6 R7)");
  endtask

  task automatic t_fast_decay_switch();
    fd_a = 3'b111; fd_b = 3'b111;
    wr(0, 6'h07); wr(6, 6'h0F);
    frame(2, "R12", "fast decay enabled on motor 0");
    wr(24, 6'h10); wr(30, 6'h10);
    frame(2, "R12", "fast decay disabled on motor 2");
    wr(0, 6'h10); wr(6, 6'h10); wr(24, 6'h07); wr(30, 6'h0F);
  endtask

  task automatic t_chain_length();
    frame(0, "R9", "single driver chain");
    frame(1, "R9", "two driver chain");
    frame(3, "R9", "last driver above range clamps");
  endtask

  task automatic t_unknown_codes();
    logic [4:0] codes [8] = '{5'h00, 5'h01, 5'h08, 5'h09, 5'h11, 5'h1F, 5'h10, 5'h16};
    dac_a = '1; dac_b = '1; ph_a = '1; ph_b = '1; fd_a = '1; fd_b = '1;
    for (int i = 0; i < 8; i++) wr(i, {1'b0, codes[i]});
    wr(8, 6'h26);
    frame(0, "R5", "unlisted codes send zero");
    load_standard();
  endtask

  task automatic t_no_flag();
    ph_a = 3'b001;
    for (int a = 0; a < 64; a++) wr(a, 6'h06);
    frame(2, "R10", "no flags caps at 64 bits");
    load_standard();
  endtask

  task automatic t_start_while_busy();
    last_drv = 2'd2;
    build_expect(2);
    pulse_start();
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    compare("R2", "restart pulse ignored");
    repeat (4) @(negedge clk);
    check(!busy && csn, "R2", "no frame after ignored start", {busy, csn}, 2'b01);
  endtask

  task automatic t_write_mid_frame();
    fd_b = 3'b100;
    last_drv = 2'd2;
    pulse_start();
    repeat (20) @(negedge clk);
    we = 1'b1; waddr = 6'd30; wdata = 6'h10;
    @(negedge clk); we = 1'b0; shadow[30] = 6'h10;
    build_expect(2);
    wait_done();
    compare("R12", "write during frame reaches later entry");
    wr(30, 6'h0F);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    load_standard();
    t_timing();
    t_three_drivers();
    t_fast_decay_switch();
    t_chain_length();
    t_unknown_codes();
    t_no_flag();
    t_start_while_busy();
    t_write_mid_frame();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule